// File: doc/BRIEF.md
# Low-Power Sleep and Wake Controller

This block decides when a small processor core drops into a low-power state and when it comes back. The core's decode logic raises a wait-for-interrupt or wait-for-event request, or signals a return from handler to thread mode. The block weighs that request against a one-bit event latch, the pending and enable vectors of the interrupt controller and three configuration bits. It then holds registered sleep and deep-sleep indications until a wake condition appears, and marks the wake with a one-cycle pulse.

Events come from an event-send pulse, an external event input and, when send-event-on-pending is set, from the rising edge of any interrupt pending bit, enabled or not. An event that arrives while no wait-for-event is sleeping is remembered in the latch. The next wait-for-event then consumes it and returns at once.

Top module: `swc_top`

## Requirements
- R1: After reset, sleep_o, deep_sleep_o and wake_o are 0 and event_latch_o is 0 (core awake, latch clear).
- R2: A wait-for-interrupt request while awake, with no interrupt both pending and enabled, sets sleep_o from the next cycle. The event latch neither prevents this sleep nor is cleared by it.
- R3: A sleep begun by wait-for-interrupt or sleep-on-exit ends only when some interrupt is both pending and enabled. In the cycle after that condition is seen, sleep_o and deep_sleep_o are 0 and wake_o is 1, and wake_o lasts exactly one cycle.
- R4: A wait-for-event request while the latch is set does not sleep, and it clears the latch in the next cycle.
- R5: A wait-for-event request with the latch clear and no wake condition sleeps. The sleep ends with a wake pulse on the first event or enabled pending interrupt, and the latch is 0 after that wake.
- R6: An event-send pulse or an external event input, while the core is not sleeping in wait-for-event, sets the latch in the next cycle.
- R7: With send-event-on-pending at 0, an interrupt that is pending but not enabled neither sets the latch nor wakes any sleep.
- R8: With send-event-on-pending at 1, a 0-to-1 change of any pending bit is an event, enabled or not. A bit that stays at 1 produces no further event.
- R9: With sleep-on-exit at 1, a handler-to-thread return while awake enters sleep with the wake rule of R3. With sleep-on-exit at 0, the return has no effect.
- R10: deep_sleep_o holds the deep-sleep select value sampled when the sleep was entered. It is 1 only while sleep_o is 1.
- R11: Requests in the same cycle rank as wait-for-interrupt, then wait-for-event, then handler-to-thread return. Only the winner acts: a losing wait-for-event does not clear the latch. All requests are ignored while sleeping.
- R12: A request whose wake condition already holds in the request cycle does not sleep. For a wait-for-event this means an event in the same cycle; the request still clears the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wfi_req_i | input | 1 | Wait-for-interrupt request pulse |
| wfe_req_i | input | 1 | Wait-for-event request pulse |
| exc_ret_i | input | 1 | Return from handler mode to thread mode |
| sev_i | input | 1 | Event-send pulse |
| ext_evt_i | input | 1 | External event input |
| irq_pend_i | input | NUM_IRQ | Interrupt pending vector |
| irq_en_i | input | NUM_IRQ | Interrupt enable vector |
| cfg_sleep_on_exit_i | input | 1 | Sleep on handler-to-thread return |
| cfg_deep_i | input | 1 | 0 selects sleep, 1 selects deep sleep |
| cfg_sev_on_pend_i | input | 1 | Pending-bit rising edges count as events |
| sleep_o | output | 1 | Core is in a low-power state |
| deep_sleep_o | output | 1 | That state is deep sleep |
| wake_o | output | 1 | One-cycle pulse on wake |
| event_latch_o | output | 1 | Event latch state |

## Verification
The hardest situation to reach from the ports is a held pending bit that is not enabled while send-event-on-pending is set. Its single rising edge must fill the latch once. Later wait-for-event requests must consume that event and then truly sleep while the bit stays high. Directed steps build this case: the latch is filled, consumed, and the same bit is then held across a second wait-for-event. A seeded random phase then changes pending bits, enables and configuration bits rarely against frequent requests, so that sleeps last long enough to meet wakes, same-cycle events and ignored requests.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_WFI   = 2'd1,
    ST_WFE   = 2'd2
  } swc_state_e;
endpackage

// File: rtl/swc_pend_edge.sv
module swc_pend_edge #(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               sev_on_pend_i,
  output logic               irq_evt_o,
  output logic               irq_wake_o
);
  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] rise;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[g] <= 1'b0;
      else         pend_q[g] <= irq_pend_i[g];
    end
    assign rise[g] = irq_pend_i[g] & ~pend_q[g];
  end

  assign irq_evt_o  = sev_on_pend_i & (|rise);
  assign irq_wake_o = |(irq_pend_i & irq_en_i);

  assert_no_pend_evt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sev_on_pend_i |-> !irq_evt_o);
endmodule

// File: rtl/swc_event_latch.sv
module swc_event_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic consume_i,
  output logic latch_o
);
  logic latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_q <= 1'b0;
    else if (consume_i) latch_q <= 1'b0;
    else if (evt_i)     latch_q <= 1'b1;
  end

  assign latch_o = latch_q;

  assert_evt_sets_latch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !consume_i) |=> latch_o);
endmodule

// File: rtl/swc_sleep_fsm.sv
module swc_sleep_fsm
  import swc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wfi_req_i,
  input  logic wfe_req_i,
  input  logic exc_ret_i,
  input  logic cfg_sleep_on_exit_i,
  input  logic cfg_deep_i,
  input  logic evt_i,
  input  logic irq_wake_i,
  input  logic latch_i,
  output logic consume_o,
  output logic sleep_o,
  output logic deep_sleep_o,
  output logic wake_o
);
  swc_state_e state_q, state_d;
  logic       deep_q, deep_d;
  logic       wake_q, wake_d;

  always_comb begin
    state_d   = state_q;
    deep_d    = deep_q;
    wake_d    = 1'b0;
    consume_o = 1'b0;
    unique case (state_q)
      ST_AWAKE: begin
        if (wfi_req_i) begin
          if (!irq_wake_i) begin
            state_d = ST_WFI;
            deep_d  = cfg_deep_i;
          end
        end else if (wfe_req_i) begin
          consume_o = 1'b1;
          if (!(latch_i || evt_i || irq_wake_i)) begin
            state_d = ST_WFE;
            deep_d  = cfg_deep_i;
          end
        end else if (exc_ret_i && cfg_sleep_on_exit_i && !irq_wake_i) begin
          state_d = ST_WFI;
          deep_d  = cfg_deep_i;
        end
      end
      ST_WFI: begin
        if (irq_wake_i) begin
          state_d = ST_AWAKE;
          deep_d  = 1'b0;
          wake_d  = 1'b1;
        end
      end
      ST_WFE: begin
        if (irq_wake_i || evt_i) begin
          state_d   = ST_AWAKE;
          deep_d    = 1'b0;
          wake_d    = 1'b1;
          consume_o = 1'b1;
        end
      end
      default: begin
        state_d = ST_AWAKE;
        deep_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      deep_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      deep_q  <= deep_d;
      wake_q  <= wake_d;
    end
  end

  assign sleep_o      = (state_q != ST_AWAKE);
  assign deep_sleep_o = deep_q;
  assign wake_o       = wake_q;

  assert_wfi_sleeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AWAKE && wfi_req_i && !irq_wake_i) |=> sleep_o);
  assert_wake_drops_sleep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (!sleep_o && $past(sleep_o)));
  assert_wake_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  assert_wfe_consumes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AWAKE && !wfi_req_i && wfe_req_i && latch_i) |=> (!sleep_o && !latch_i));
  assert_deep_in_sleep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_sleep_o |-> sleep_o);
  assert_stay_asleep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o && !irq_wake_i && !evt_i) |=> (sleep_o && !wake_o));
endmodule

// File: rtl/swc_top.sv
module swc_top #(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wfi_req_i,
  input  logic               wfe_req_i,
  input  logic               exc_ret_i,
  input  logic               sev_i,
  input  logic               ext_evt_i,
  input  logic [NUM_IRQ-1:0] irq_pend_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  input  logic               cfg_sleep_on_exit_i,
  input  logic               cfg_deep_i,
  input  logic               cfg_sev_on_pend_i,
  output logic               sleep_o,
  output logic               deep_sleep_o,
  output logic               wake_o,
  output logic               event_latch_o
);
  logic irq_evt, irq_wake, evt, consume;

  swc_pend_edge #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_pend_i   (irq_pend_i),
    .irq_en_i     (irq_en_i),
    .sev_on_pend_i(cfg_sev_on_pend_i),
    .irq_evt_o    (irq_evt),
    .irq_wake_o   (irq_wake)
  );

  assign evt = sev_i | ext_evt_i | irq_evt;

  swc_event_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .consume_i(consume),
    .latch_o  (event_latch_o)
  );

  swc_sleep_fsm u_fsm (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .wfi_req_i          (wfi_req_i),
    .wfe_req_i          (wfe_req_i),
    .exc_ret_i          (exc_ret_i),
    .cfg_sleep_on_exit_i(cfg_sleep_on_exit_i),
    .cfg_deep_i         (cfg_deep_i),
    .evt_i              (evt),
    .irq_wake_i         (irq_wake),
    .latch_i            (event_latch_o),
    .consume_o          (consume),
    .sleep_o            (sleep_o),
    .deep_sleep_o       (deep_sleep_o),
    .wake_o             (wake_o)
  );

  assert_exit_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_o && exc_ret_i && !cfg_sleep_on_exit_i && !wfi_req_i && !wfe_req_i) |=> !sleep_o);
endmodule

// File: tb/swc_top_tb_top.sv
module swc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wfi_req_i, wfe_req_i, exc_ret_i, sev_i, ext_evt_i;
  logic [NIRQ-1:0] irq_pend_i, irq_en_i;
  logic cfg_sleep_on_exit_i, cfg_deep_i, cfg_sev_on_pend_i;
  logic sleep_o, deep_sleep_o, wake_o, event_latch_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_cnt = 0;

  // model state: 0 awake, 1 interrupt sleep, 2 event sleep
  int m_st;
  logic m_deep, m_wake, m_latch;
  logic [NIRQ-1:0] m_pq;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  swc_top #(.NUM_IRQ(NIRQ)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wfi_req_i(wfi_req_i), .wfe_req_i(wfe_req_i), .exc_ret_i(exc_ret_i),
    .sev_i(sev_i), .ext_evt_i(ext_evt_i),
    .irq_pend_i(irq_pend_i), .irq_en_i(irq_en_i),
    .cfg_sleep_on_exit_i(cfg_sleep_on_exit_i), .cfg_deep_i(cfg_deep_i),
    .cfg_sev_on_pend_i(cfg_sev_on_pend_i),
    .sleep_o(sleep_o), .deep_sleep_o(deep_sleep_o), .wake_o(wake_o),
    .event_latch_o(event_latch_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt == 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<100000", cyc_cnt);
      summary();
      $finish;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%b exp=%b at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_deep = 0; m_wake = 0; m_latch = 0; m_pq = '0;
  endtask

  task automatic model_step();
    logic evt, wk, cons;
    int ns;
    logic nd, nw;
    evt  = sev_i | ext_evt_i | (cfg_sev_on_pend_i & (|(irq_pend_i & ~m_pq)));
    wk   = |(irq_pend_i & irq_en_i);
    ns = m_st; nd = m_deep; nw = 0; cons = 0;
    if (m_st == 0) begin
      if (wfi_req_i) begin
        if (!wk) begin ns = 1; nd = cfg_deep_i; end
      end else if (wfe_req_i) begin
        cons = 1;
        if (!(m_latch | evt | wk)) begin ns = 2; nd = cfg_deep_i; end
      end else if (exc_ret_i && cfg_sleep_on_exit_i && !wk) begin
        ns = 1; nd = cfg_deep_i;
      end
    end else if (m_st == 1) begin
      if (wk) begin ns = 0; nd = 0; nw = 1; end
    end else begin
      if (wk | evt) begin ns = 0; nd = 0; nw = 1; cons = 1; end
    end
    m_latch = cons ? 1'b0 : (m_latch | evt);
    m_pq = irq_pend_i; m_st = ns; m_deep = nd; m_wake = nw;
  endtask

  task automatic cmp_model();
    check("R2 R5 R9 sleep_o vs model", sleep_o, m_st != 0);
    check("R10 deep_sleep_o vs model", deep_sleep_o, m_deep);
    check("R3 wake_o vs model", wake_o, m_wake);
    check("R4 R6 R8 event_latch_o vs model", event_latch_o, m_latch);
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    cmp_model();
  endtask

  task automatic pulses_off();
    wfi_req_i = 0; wfe_req_i = 0; exc_ret_i = 0; sev_i = 0; ext_evt_i = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    pulses_off();
    irq_pend_i = '0; irq_en_i = '0;
    cfg_sleep_on_exit_i = 0; cfg_deep_i = 0; cfg_sev_on_pend_i = 0;
    model_reset();
    repeat (3) @(negedge clk_i);
    check("R1 sleep_o in reset", sleep_o, 1'b0);
    check("R1 latch in reset", event_latch_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 sleep_o after reset", sleep_o, 1'b0);
    check("R1 deep_sleep_o after reset", deep_sleep_o, 1'b0);
    check("R1 wake_o after reset", wake_o, 1'b0);
    check("R1 latch after reset", event_latch_o, 1'b0);

    // R6: event-send and external event set latch
    sev_i = 1; cyc(); pulses_off();
    check("R6 sev sets latch", event_latch_o, 1'b1);
    // R4: wait-for-event consumes latch without sleeping
    wfe_req_i = 1; cyc(); pulses_off();
    check("R4 no sleep with latch", sleep_o, 1'b0);
    check("R4 latch cleared", event_latch_o, 1'b0);
    ext_evt_i = 1; cyc(); pulses_off();
    check("R6 ext event sets latch", event_latch_o, 1'b1);
    wfe_req_i = 1; cyc(); pulses_off();
    // R5: event sleep and wake
    wfe_req_i = 1; cyc(); pulses_off();
    check("R5 wfe sleeps", sleep_o, 1'b1);
    cyc(); cyc();
    check("R5 still asleep", sleep_o, 1'b1);
    ext_evt_i = 1; cyc(); pulses_off();
    check("R5 woke", sleep_o, 1'b0);
    check("R3 wake pulse", wake_o, 1'b1);
    check("R5 latch clear after wake", event_latch_o, 1'b0);
    cyc();
    check("R3 wake one cycle", wake_o, 1'b0);

    // R2: wfi ignores latch
    sev_i = 1; cyc(); pulses_off();
    wfi_req_i = 1; cyc(); pulses_off();
    check("R2 wfi sleeps with latch set", sleep_o, 1'b1);
    check("R2 latch kept", event_latch_o, 1'b1);
    wfe_req_i = 1; sev_i = 1; cyc(); pulses_off();
    check("R3 event does not end wfi sleep", sleep_o, 1'b1);
    check("R11 wfe while asleep keeps latch", event_latch_o, 1'b1);
    // R7: disabled pending ignored with send-event-on-pending clear
    irq_pend_i = 8'h08; cyc(); cyc();
    check("R7 disabled pending no wake", sleep_o, 1'b0 ^ 1'b1);
    irq_en_i = 8'h08; cyc();
    check("R3 enabled pending wakes", wake_o, 1'b1);
    check("R3 sleep dropped", sleep_o, 1'b0);
    irq_pend_i = '0; irq_en_i = '0; cyc();
    wfe_req_i = 1; cyc(); pulses_off();
    check("R4 consumed", event_latch_o, 1'b0);
    irq_pend_i = 8'h02; cyc();
    check("R7 disabled pending no latch", event_latch_o, 1'b0);
    irq_pend_i = '0; cyc();

    // R8: rising edge of pending is one event
    cfg_sev_on_pend_i = 1;
    irq_pend_i = 8'h20; cyc();
    check("R8 pending edge sets latch", event_latch_o, 1'b1);
    wfe_req_i = 1; cyc(); pulses_off();
    check("R8 latch consumed", event_latch_o, 1'b0);
    wfe_req_i = 1; cyc(); pulses_off();
    check("R8 held pending no new event", sleep_o, 1'b1);
    irq_pend_i = 8'h24; cyc();
    check("R8 new edge wakes", wake_o, 1'b1);
    irq_pend_i = '0; cfg_sev_on_pend_i = 0; cyc();

    // R10: deep select captured at entry
    cfg_deep_i = 1; wfi_req_i = 1; cyc(); pulses_off();
    cfg_deep_i = 0; cyc();
    check("R10 deep sleep held", deep_sleep_o, 1'b1);
    irq_pend_i = 8'h01; irq_en_i = 8'h01; cyc();
    check("R10 deep drops on wake", deep_sleep_o, 1'b0);
    irq_pend_i = '0; irq_en_i = '0; cyc();
    wfi_req_i = 1; cyc(); pulses_off();
    check("R10 normal sleep", deep_sleep_o, 1'b0);
    irq_pend_i = 8'h01; irq_en_i = 8'h01; cyc();
    irq_pend_i = '0; irq_en_i = '0; cyc();

    // R9: sleep-on-exit
    exc_ret_i = 1; cyc(); pulses_off();
    check("R9 return ignored when off", sleep_o, 1'b0);
    cfg_sleep_on_exit_i = 1; exc_ret_i = 1; cyc(); pulses_off();
    check("R9 return sleeps when on", sleep_o, 1'b1);
    ext_evt_i = 1; cyc(); pulses_off();
    check("R9 event no wake", sleep_o, 1'b1);
    irq_pend_i = 8'h40; irq_en_i = 8'h40; cyc();
    check("R9 irq wakes", wake_o, 1'b1);
    irq_pend_i = '0; irq_en_i = '0; cfg_sleep_on_exit_i = 0; cyc();

    // R11: priority, latch set from earlier event
    wfi_req_i = 1; wfe_req_i = 1; exc_ret_i = 1; cyc(); pulses_off();
    check("R11 wfi wins", sleep_o, 1'b1);
    check("R11 losing wfe keeps latch", event_latch_o, 1'b1);
    irq_pend_i = 8'h10; irq_en_i = 8'h10; cyc();
    // R12: wake condition already present
    wfi_req_i = 1; cyc(); pulses_off();
    check("R12 wfi with enabled pending stays awake", sleep_o, 1'b0);
    irq_pend_i = '0; irq_en_i = '0;
    wfe_req_i = 1; cyc(); pulses_off();
    check("R12 wfe consumes latch", event_latch_o, 1'b0);
    wfe_req_i = 1; sev_i = 1; cyc(); pulses_off();
    check("R12 wfe with same-cycle event stays awake", sleep_o, 1'b0);
    check("R12 same-cycle event consumed", event_latch_o, 1'b0);

    // random phase
    for (int i = 0; i < 5000; i++) begin
      wfi_req_i = ($urandom_range(7) == 0);
      wfe_req_i = ($urandom_range(5) == 0);
      exc_ret_i = ($urandom_range(7) == 0);
      sev_i     = ($urandom_range(15) == 0);
      ext_evt_i = ($urandom_range(19) == 0);
      if ($urandom_range(5) == 0) irq_pend_i[$urandom_range(NIRQ-1)] ^= 1'b1;
      if ($urandom_range(11) == 0) irq_en_i = NIRQ'($urandom) & NIRQ'($urandom);
      if ($urandom_range(31) == 0) cfg_sleep_on_exit_i = $urandom_range(1);
      if ($urandom_range(31) == 0) cfg_sev_on_pend_i = $urandom_range(1);
      if ($urandom_range(7) == 0) cfg_deep_i = $urandom_range(1);
      cyc();
    end
    pulses_off();
    summary();
    $finish;
  end
endmodule